// File: doc/BRIEF.md
# Single-Cycle Integer Core for a Small Load/Store Subset

This block is a complete processor core that retires one instruction in every clock cycle. In a single cycle it fetches the word at the program counter, decodes it, reads two source registers and runs the ALU. In that same cycle it either accesses data memory or resolves a branch, then commits the result on the rising edge. It executes nine instructions. The register-to-register group is add, sub, and, or and slt. The immediate and memory group is addi, lw and sw. The only control-flow instruction is beq. All instructions use the standard 32-bit encodings.

Instruction memory and data memory are word arrays held inside the block. A preload port fills either memory one word per cycle, and the core stalls in any cycle that uses this port. Two combinational inspection ports return any register and any data-memory word, so a test environment can compare the architectural state against a model. Every 16-bit immediate is sign-extended. For this reason the logical-immediate forms of and and or are not part of the set, and the core treats them as unknown. A branch uses the main ALU's subtraction and its zero flag, and there is no separate comparator.

Top module: `mcore_top`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears all 32 registers. While `rst` is high the core makes no register or data-memory write.
- R2: When no branch is taken, the program counter advances by 4 on each rising edge. Instructions are fetched from the instruction-memory word selected by PC bits [IMEM_AW+1:2], so the PC wraps around the memory.
- R3: beq (opcode 0x04) subtracts register rt from register rs in the ALU. It is taken only when the ALU zero flag is 1, and then the PC becomes PC + 4 + (sign-extended imm << 2). A branch that is not taken follows R2.
- R4: An R-type instruction has opcode 0 and shamt bits [10:6] equal to 0. It writes rs OP rt to register rd, with funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or and 0x2A slt. slt yields 1 when rs < rt as signed 32-bit values and 0 otherwise.
- R5: addi (opcode 0x08) writes rs + sign-extended imm[15:0] to register rt.
- R6: lw (0x23) and sw (0x2B) form the address rs + sign-extended imm. Address bits [DMEM_AW+1:2] select the data word, and the other address bits are ignored. lw writes the word to rt and sw stores rt.
- R7: Register 0 always reads as zero, and any write to it is discarded.
- R8: Any other opcode or funct makes no register write and no memory write, and the PC still advances by 4. This covers andi (0x0C), ori (0x0D), funct 0, and R-type words with a nonzero shamt.
- R9: While `ld_en` is 1, the word `ld_data` is written at word index `ld_addr`: into instruction memory when `ld_sel` is 0, and into data memory when it is 1. In that cycle the PC holds its value and the core makes no register or memory write.
- R10: `dbg_reg_data` shows register `dbg_reg_addr` and `dbg_mem_data` shows data word `dbg_mem_addr`. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write strobe; stalls the core |
| ld_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_reg_addr | input | 5 | Register inspection index |
| dbg_reg_data | output | 32 | Register inspection value |
| dbg_mem_addr | input | DMEM_AW | Data-memory inspection word index |
| dbg_mem_data | output | 32 | Data-memory inspection value |
| pc | output | 32 | Current program counter |

## Verification
The bench builds the core with 64 instruction words and 16 data words. The instruction memory is large enough for a 64-instruction random program to wrap the PC several times in one run. The small data memory makes random load and store addresses alias often, so the ignored upper address bits and read-after-write through memory are exercised constantly. Backward and forward branches over short distances, combined with registers drawn from a pool of eight, make taken branches and writes to register 0 frequent.

// File: rtl/mcore_pkg.sv
`timescale 1ns/1ps
package mcore_pkg;

  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RIDX_W = $clog2(NREGS);

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic    valid;
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_we;
    logic    mem_to_reg;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] pc_next(input logic [XLEN-1:0] cur,
                                              input logic [XLEN-1:0] off,
                                              input logic            take);
    logic [XLEN-1:0] seq;
    seq = cur + XLEN'(4);
    return take ? seq + (off << 2) : seq;
  endfunction

endpackage

// File: rtl/mcore_decode.sv
`timescale 1ns/1ps
module mcore_decode
  import mcore_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctl
);

  always_comb begin
    ctl = '{valid: 1'b0, reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0,
            mem_we: 1'b0, mem_to_reg: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    case (opcode)
      OPC_RTYPE: begin
        if (shamt == '0) begin
          ctl.dst_rd = 1'b1;
          case (funct)
            FN_ADD: begin ctl.valid = 1'b1; ctl.alu_op = ALU_ADD; end
            FN_SUB: begin ctl.valid = 1'b1; ctl.alu_op = ALU_SUB; end
            FN_AND: begin ctl.valid = 1'b1; ctl.alu_op = ALU_AND; end
            FN_OR:  begin ctl.valid = 1'b1; ctl.alu_op = ALU_OR;  end
            FN_SLT: begin ctl.valid = 1'b1; ctl.alu_op = ALU_SLT; end
            default: ctl.valid = 1'b0;
          endcase
          ctl.reg_we = ctl.valid;
        end
      end
      OPC_ADDI: begin
        ctl.valid   = 1'b1;
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OPC_LW: begin
        ctl.valid      = 1'b1;
        ctl.reg_we     = 1'b1;
        ctl.src_imm    = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      OPC_SW: begin
        ctl.valid   = 1'b1;
        ctl.mem_we  = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctl.valid  = 1'b1;
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ctl.valid = 1'b0;
    endcase
  end

  AST_UNKNOWN_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    !ctl.valid |-> (!ctl.reg_we && !ctl.mem_we && !ctl.branch)); // R8

  AST_BRANCH_USES_SUB: assert property (@(posedge clk) disable iff (rst)
    ctl.branch |-> (ctl.alu_op == ALU_SUB && !ctl.reg_we)); // R3

endmodule

// File: rtl/mcore_alu.sv
`timescale 1ns/1ps
module mcore_alu
  import mcore_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);

  AST_SLT_BOOL: assert property (@(posedge clk) disable iff (rst)
    (op == ALU_SLT) |-> (y[XLEN-1:1] == '0)); // R4

  AST_SUB_ZERO_EQ: assert property (@(posedge clk) disable iff (rst)
    (op == ALU_SUB && zero) |-> (a == b)); // R3

endmodule

// File: rtl/mcore_regfile.sv
`timescale 1ns/1ps
module mcore_regfile
  import mcore_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] wa,
  input  logic [XLEN-1:0]   wd,
  input  logic [RIDX_W-1:0] ra1,
  input  logic [RIDX_W-1:0] ra2,
  input  logic [RIDX_W-1:0] ra3,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2,
  output logic [XLEN-1:0]   rd3
);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  function automatic logic [XLEN-1:0] rd_port(input logic [RIDX_W-1:0] idx);
    return (idx == '0) ? '0 : regs[idx];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
  assign rd3 = rd_port(ra3);

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd))); // R4

  AST_ZERO_REG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (we && (wa == '0)) |=> $stable(rd3)); // R7

endmodule

// File: rtl/mcore_top.sv
`timescale 1ns/1ps
module mcore_top
  import mcore_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IMEM_AW    = $clog2(IMEM_WORDS),
  localparam int DMEM_AW    = $clog2(DMEM_WORDS),
  localparam int LD_AW      = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic               ld_sel,
  input  logic [LD_AW-1:0]   ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  input  logic [RIDX_W-1:0]  dbg_reg_addr,
  output logic [XLEN-1:0]    dbg_reg_data,
  input  logic [DMEM_AW-1:0] dbg_mem_addr,
  output logic [XLEN-1:0]    dbg_mem_data,
  output logic [XLEN-1:0]    pc
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0]    pc_q;
  logic [XLEN-1:0]    instr;
  ctrl_t              ctl;
  logic [XLEN-1:0]    imm_ext;
  logic [XLEN-1:0]    rs_val, rt_val;
  logic [XLEN-1:0]    alu_b, alu_y;
  logic               alu_zero;
  logic [RIDX_W-1:0]  wr_idx;
  logic [XLEN-1:0]    wb_val;
  logic [DMEM_AW-1:0] dm_idx;
  logic [XLEN-1:0]    dm_rd;

  // named events for the checks
  logic run;
  logic br_taken;
  logic rf_we;
  logic dm_we;

  assign run      = !rst && !ld_en;
  assign instr    = imem[pc_q[IMEM_AW+1:2]];
  assign imm_ext  = sext16(instr[15:0]);

  mcore_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .shamt  (instr[10:6]),
    .ctl    (ctl)
  );

  mcore_regfile u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (wr_idx),
    .wd  (wb_val),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .ra3 (dbg_reg_addr),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .rd3 (dbg_reg_data)
  );

  assign alu_b = ctl.src_imm ? imm_ext : rt_val;

  mcore_alu u_alu (
    .clk  (clk),
    .rst  (rst),
    .op   (ctl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dm_idx   = alu_y[DMEM_AW+1:2];
  assign dm_rd    = dmem[dm_idx];
  assign wb_val   = ctl.mem_to_reg ? dm_rd : alu_y;
  assign wr_idx   = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we    = run && ctl.reg_we;
  assign dm_we    = run && ctl.mem_we;
  assign br_taken = run && ctl.branch && alu_zero;

  always_ff @(posedge clk) begin
    if (rst)      pc_q <= '0;
    else if (run) pc_q <= pc_next(pc_q, imm_ext, br_taken);
  end

  always_ff @(posedge clk) begin
    if (ld_en && !ld_sel) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_sel) dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (dm_we)      dmem[dm_idx] <= rt_val;
  end

  assign dbg_mem_data = dmem[dbg_mem_addr];
  assign pc           = pc_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !br_taken) |=> (pc_q == $past(pc_q) + 32'd4)); // R2

  AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc_q == $past(pc_q) + 32'd4 + ($past(imm_ext) << 2))); // R3

  AST_BR_COND: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (rs_val == rt_val)); // R3

  AST_LOAD_STALL: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> $stable(pc_q)); // R9

  AST_DMEM_STORE: assert property (@(posedge clk) disable iff (rst)
    dm_we |=> (dmem[$past(dm_idx)] == $past(rt_val))); // R6

  AST_RESET_PC: assert property (@(posedge clk)
    rst |=> (pc_q == '0)); // R1

endmodule

// File: tb/mcore_top_tb_top.sv
`timescale 1ns/1ps
module mcore_top_tb_top;

  localparam int IW   = 64;
  localparam int DW   = 16;
  localparam int LDAW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_reg_addr = '0;
  logic [31:0] dbg_reg_data;
  logic [3:0]  dbg_mem_addr = '0;
  logic [31:0] dbg_mem_data;
  logic [31:0] pc;

  always #10 clk = ~clk;

  mcore_top #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_reg_addr(dbg_reg_addr), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data), .pc(pc)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_reg  [32];
  logic [31:0] m_imem [IW];
  logic [31:0] m_dmem [DW];
  logic [31:0] m_pc;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic model_step();
    logic [31:0] ins, a, b, im, res, nxt, ea;
    logic [5:0]  op, fn;
    int rs, rt, rd;
    bit wr;
    ins = m_imem[(m_pc >> 2) % IW];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = m_reg[rs]; b = m_reg[rt]; im = sx(ins[15:0]);
    ea = a + im;
    nxt = m_pc + 4;
    wr = 1'b1; res = '0;
    case (op)
      6'h00: begin
        if (ins[10:6] != 0) wr = 1'b0;
        else case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: wr = 1'b0;
        endcase
        if (wr && rd != 0) m_reg[rd] = res;
      end
      6'h08: if (rt != 0) m_reg[rt] = a + im;
      6'h23: if (rt != 0) m_reg[rt] = m_dmem[(ea >> 2) % DW];
      6'h2B: m_dmem[(ea >> 2) % DW] = b;
      6'h04: if (a == b) nxt = nxt + (im << 2);
      default: ;
    endcase
    m_pc = nxt;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) begin
      chk("R2/R3", "pc", pc, m_pc);
      model_step();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic load(input bit sel, input int addr, input logic [31:0] data);
    ld_en = 1'b1; ld_sel = sel; ld_addr = 6'(addr); ld_data = data;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
    if (sel) m_dmem[addr % DW] = data;
    else     m_imem[addr % IW] = data;
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    dbg_reg_addr = 5'(r);
    #0.1;
    v = dbg_reg_data;
  endtask

  task automatic rd_mem(input int w, output logic [31:0] v);
    dbg_mem_addr = 4'(w);
    #0.1;
    v = dbg_mem_data;
  endtask

  task automatic cmp_state(input string req);
    logic [31:0] v;
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      chk(req, $sformatf("reg%0d", r), v, m_reg[r]);
    end
    for (int w = 0; w < DW; w++) begin
      rd_mem(w, v);
      chk(req, $sformatf("dmem%0d", w), v, m_dmem[w]);
    end
  endtask

  function automatic logic [31:0] rand_instr();
    int k, rs, rt, rd;
    logic [15:0] imm;
    logic [5:0] fns [5];
    int boffs [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    boffs[0] = -3; boffs[1] = -2; boffs[2] = 1; boffs[3] = 2; boffs[4] = 3;
    k  = $urandom % 12;
    rs = $urandom % 8; rt = $urandom % 8; rd = $urandom % 8;
    if (k < 5) return enc_r(fns[k], rs, rt, rd);
    if (k < 7) return enc_i(6'h08, rs, rt, 16'($urandom));
    imm = 16'(int'($urandom % 128) - 64);
    if (k == 7) return enc_i(6'h23, rs, rt, imm);
    if (k == 8) return enc_i(6'h2B, rs, rt, imm);
    if (k < 11) return enc_i(6'h04, rs, rt, 16'(boffs[$urandom % 5]));
    return enc_i(($urandom % 2) ? 6'h0C : 6'h0D, rs, rt, 16'($urandom));
  endfunction

  task automatic core_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 32; r++) m_reg[r] = '0;
    m_pc = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, pc0;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < IW; i++) m_imem[i] = '0;
    for (int i = 0; i < DW; i++) m_dmem[i] = '0;
    @(negedge clk);

    // directed program, loaded while reset holds the core
    rst = 1'b1;
    load(0, 0,  enc_i(6'h08, 0, 1, 16'hFFFB));
    load(0, 1,  enc_i(6'h08, 0, 2, 16'd7));
    load(0, 2,  enc_r(6'h2A, 1, 2, 3));
    load(0, 3,  enc_r(6'h2A, 2, 1, 4));
    load(0, 4,  enc_r(6'h22, 1, 2, 5));
    load(0, 5,  enc_r(6'h24, 1, 2, 6));
    load(0, 6,  enc_r(6'h25, 1, 2, 7));
    load(0, 7,  enc_r(6'h20, 1, 2, 0));
    load(0, 8,  enc_i(6'h2B, 0, 5, 16'd8));
    load(0, 9,  enc_i(6'h23, 0, 8, 16'd8));
    load(0, 10, enc_i(6'h0C, 2, 9, 16'hFFFF));
    load(0, 11, enc_i(6'h04, 1, 2, 16'd5));
    load(0, 12, enc_i(6'h04, 3, 3, 16'd2));
    load(0, 13, enc_i(6'h08, 0, 10, 16'd1));
    load(0, 14, enc_i(6'h08, 0, 10, 16'd2));
    load(0, 15, enc_i(6'h08, 0, 11, 16'd3));
    for (int i = 16; i < IW; i++) load(0, i, '0);
    for (int i = 0; i < DW; i++) load(1, i, 32'h1000 + 32'(i));
    core_reset();

    chk("R1", "pc after reset", pc, 32'h0);
    rd_reg(1, v); chk("R1", "reg1 after reset", v, 32'h0);

    step_n(13);
    chk("R3", "pc after taken beq", pc, 32'd60);
    pc0 = pc;
    load(1, 5, 32'hA5A5_0005);
    chk("R9", "pc held during preload", pc, pc0);
    rd_reg(11, v); chk("R9", "no write during preload", v, 32'h0);
    rd_mem(5, v);  chk("R9", "preloaded dmem word", v, 32'hA5A5_0005);
    step_n(1);

    rd_reg(1, v);  chk("R5",  "addi negative", v, 32'hFFFF_FFFB);
    rd_reg(2, v);  chk("R5",  "addi positive", v, 32'd7);
    rd_reg(3, v);  chk("R4",  "slt neg<pos", v, 32'd1);
    rd_reg(4, v);  chk("R4",  "slt pos<neg", v, 32'd0);
    rd_reg(5, v);  chk("R4",  "sub", v, 32'hFFFF_FFF4);
    rd_reg(6, v);  chk("R4",  "and", v, 32'd3);
    rd_reg(7, v);  chk("R4",  "or", v, 32'hFFFF_FFFF);
    rd_reg(0, v);  chk("R7",  "reg0 after write", v, 32'h0);
    rd_reg(8, v);  chk("R6",  "lw after sw", v, 32'hFFFF_FFF4);
    rd_mem(2, v);  chk("R6",  "sw word", v, 32'hFFFF_FFF4);
    rd_reg(9, v);  chk("R8",  "andi not executed", v, 32'h0);
    rd_reg(10, v); chk("R3",  "skipped by branch", v, 32'h0);
    rd_reg(11, v); chk("R10", "branch target executed", v, 32'd3);
    cmp_state("R10");

    // constrained random programs
    for (int round = 0; round < 4; round++) begin
      rst = 1'b1;
      for (int i = 0; i < IW; i++) load(0, i, rand_instr());
      for (int i = 0; i < DW; i++) load(1, i, $urandom);
      core_reset();
      chk("R1", "pc after reset", pc, 32'h0);
      step_n(150);
      pc0 = pc;
      load(1, $urandom % DW, $urandom);
      chk("R9", "pc held during preload", pc, pc0);
      step_n(150);
      cmp_state("R4/R5/R6/R7/R8");
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", "pc held in reset", pc, 32'h0);
      rd_reg(1 + round, v); chk("R1", "reg cleared", v, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule